// File: doc/BRIEF.md
# Shared-Interrupt Distributor Register File

This block is the memory-mapped register file of a shared-interrupt distributor that always runs with affinity routing enabled and a single security state. A host issues 32-bit reads and writes on a simple request/response register bus. Each request is a single-cycle `req_valid` pulse. The response (`rsp_valid`, `rsp_rdata`, `rsp_err`) comes back one clock later.

The block stores the state for the shared interrupts:
- enable bits and pending bits, each written through separate set and clear windows;
- one priority byte per interrupt;
- two trigger-configuration bits per interrupt;
- one global group-1 enable.

It also returns fixed identification and type values. Several windows of the 64 KiB frame are hardwired:
- the first 32 (private) interrupts of every per-interrupt array;
- the active, group-modifier and access-control arrays;
- the legacy CPU-target and software-interrupt registers;
- the status and message-interrupt registers.

Prioritisation and delivery of interrupts are handled elsewhere. This block only decodes addresses, applies access semantics and holds the state.

Top module: `irq_dist_regfile`

## Requirements
- R1: After reset, every enable, pending, priority and configuration bit is 0 and the group-1 enable is 0.
- R2: The control word at 0x0000 always reads bit 6 and bit 4 as 1. Bit 1 stores the written group-1 enable and reads it back. Bit 0 and all other bits read 0, whatever is written.
- R3: The type word at 0x0004 reads NUM_IRQ/32-1 in bits [4:0] and 9 in bits [23:19]. All other bits read 0, and writes are ignored.
- R4: In the set-enable window (0x100-0x17F) and the clear-enable window (0x180-0x1FF), word k covers interrupts 32k..32k+31. Writing a 1 sets (or clears) the matching enable bit, and writing a 0 leaves it unchanged. Reads in either window return the current enable bits.
- R5: The set-pending window (0x200-0x27F) and the clear-pending window (0x280-0x2FF) behave the same way for the pending bits.
- R6: The private-interrupt part of each array reads 0 and ignores writes. This is word 0 of the enable and pending windows, the words at 0x400-0x41F of the priority array, and the words at 0xC00-0xC07 of the configuration array.
- R7: The group window (0x080-0x0FF) reads 0xFFFFFFFF and ignores writes.
- R8: Priority words at 0x400-0x7FF hold one byte per interrupt, with interrupt n in byte n. They read back as written.
- R9: Configuration words at 0xC00-0xCFF hold two bits per interrupt, with word k covering interrupts 16k..16k+15. They read back as written.
- R10: These windows read 0 and ignore writes: 0x010, 0x040, 0x048, 0x050, 0x058, 0x300-0x3FF, 0x800-0xBFF, 0xD00-0xD7F, 0xE00-0xEFF, 0xF00 and 0xF10-0xF2F.
- R11: In the identification window 0xFFD0-0xFFFF, the word at 0xFFE8 reads 0x3B and every other word reads 0. Writes are ignored.
- R12: An access to any other offset, or to an address that is not word-aligned, reads 0, ignores writes and returns `rsp_err`=1. Decoded accesses return `rsp_err`=0, and write responses carry data 0.
- R13: Enable, pending, priority and configuration state for interrupts at or above NUM_IRQ reads 0 and ignores writes.
- R14: Each request cycle produces exactly one response on the following cycle, and no response appears without a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte offset within the 64 KiB frame |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| rsp_err | output | 1 | Undecoded or misaligned access |

## Verification
The checker asserts the following on every cycle:
- the one-cycle response timing;
- the forced control bits;
- the type value;
- the all-ones group window;
- the identification constant;
- zero data with every error response;
- the zero private enable word.

Whether a write sets, clears or is dropped shows only across a sequence of accesses. The bench therefore covers stored state with a shadow model under random and directed traffic, followed by a full sweep of every array. That sweep also shows that writes to hardwired and undecoded windows left no trace.

// File: rtl/dist_pkg.sv
package dist_pkg;
   // Interrupts reserved as private; their slices are hardwired to zero
   localparam int PRIV_IRQ  = 32;
   localparam int ID_BITS   = 10;
   localparam logic [31:0] ID2_VALUE = 32'h0000_003B;

   typedef enum logic [3:0] {
      RG_CTRL,
      RG_TYPE,
      RG_RAZ,
      RG_RAO,
      RG_ENA_SET,
      RG_ENA_CLR,
      RG_PND_SET,
      RG_PND_CLR,
      RG_PRIO,
      RG_CFG,
      RG_ID2,
      RG_NONE
   } region_e;
endpackage

// File: rtl/dist_decode.sv
module dist_decode
   import dist_pkg::*;
(
   input  logic [15:0] addr,
   output region_e     region
);
   logic [15:0] a;

   always_comb begin
      a = addr;
      if (a[1:0] != 2'b00)                         region = RG_NONE;
      else if (a == 16'h0000)                      region = RG_CTRL;
      else if (a == 16'h0004)                      region = RG_TYPE;
      else if (a == 16'h0010 || a == 16'h0040 ||
               a == 16'h0048 || a == 16'h0050 ||
               a == 16'h0058)                      region = RG_RAZ;
      else if (a >= 16'h0080 && a < 16'h0100)      region = RG_RAO;
      else if (a >= 16'h0100 && a < 16'h0180)      region = RG_ENA_SET;
      else if (a >= 16'h0180 && a < 16'h0200)      region = RG_ENA_CLR;
      else if (a >= 16'h0200 && a < 16'h0280)      region = RG_PND_SET;
      else if (a >= 16'h0280 && a < 16'h0300)      region = RG_PND_CLR;
      else if (a >= 16'h0300 && a < 16'h0400)      region = RG_RAZ;
      else if (a >= 16'h0400 && a < 16'h0800)      region = RG_PRIO;
      else if (a >= 16'h0800 && a < 16'h0C00)      region = RG_RAZ;
      else if (a >= 16'h0C00 && a < 16'h0D00)      region = RG_CFG;
      else if (a >= 16'h0D00 && a < 16'h0D80)      region = RG_RAZ;
      else if (a >= 16'h0E00 && a < 16'h0F00)      region = RG_RAZ;
      else if (a == 16'h0F00)                      region = RG_RAZ;
      else if (a >= 16'h0F10 && a < 16'h0F30)      region = RG_RAZ;
      else if (a == 16'hFFE8)                      region = RG_ID2;
      else if (a >= 16'hFFD0)                      region = RG_RAZ;
      else                                         region = RG_NONE;
   end
endmodule

// File: rtl/dist_bitarray.sv
module dist_bitarray #(
   parameter int NUM_WORDS  = 4,
   parameter int FIRST_WORD = 1,
   parameter int IDX_W      = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_en,
   input  logic             clr_en,
   input  logic [IDX_W-1:0] idx,
   input  logic [31:0]      wdata,
   output logic [31:0]      rd_word
);
   localparam int FLAT_W = NUM_WORDS * 32;

   logic [FLAT_W-1:0] flat;

   generate
      if (NUM_WORDS > (1 << IDX_W)) begin : g_bad_idx
         $error("dist_bitarray: index too narrow for word count");
      end
      for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
         if (w < FIRST_WORD) begin : g_fixed
            assign flat[w*32 +: 32] = '0;
         end else begin : g_store
            logic [31:0] word_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  word_q <= '0;
               else if (set_en && idx == IDX_W'(w))
                  word_q <= word_q | wdata;
               else if (clr_en && idx == IDX_W'(w))
                  word_q <= word_q & ~wdata;
            end
            assign flat[w*32 +: 32] = word_q;
         end
      end
   endgenerate

   always_comb begin
      rd_word = '0;
      for (int w = 0; w < NUM_WORDS; w++)
         if (idx == IDX_W'(w)) rd_word = flat[w*32 +: 32];
   end
endmodule

// File: rtl/dist_wordarray.sv
module dist_wordarray #(
   parameter int NUM_WORDS  = 32,
   parameter int FIRST_WORD = 8,
   parameter int IDX_W      = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] idx,
   input  logic [31:0]      wdata,
   output logic [31:0]      rd_word
);
   localparam int FLAT_W = NUM_WORDS * 32;

   logic [FLAT_W-1:0] flat;

   generate
      if (NUM_WORDS > (1 << IDX_W)) begin : g_bad_idx
         $error("dist_wordarray: index too narrow for word count");
      end
      for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
         if (w < FIRST_WORD) begin : g_fixed
            assign flat[w*32 +: 32] = '0;
         end else begin : g_store
            logic [31:0] word_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  word_q <= '0;
               else if (wr_en && idx == IDX_W'(w))
                  word_q <= wdata;
            end
            assign flat[w*32 +: 32] = word_q;
         end
      end
   endgenerate

   always_comb begin
      rd_word = '0;
      for (int w = 0; w < NUM_WORDS; w++)
         if (idx == IDX_W'(w)) rd_word = flat[w*32 +: 32];
   end
endmodule

// File: rtl/irq_dist_regfile.sv
module irq_dist_regfile
   import dist_pkg::*;
#(
   parameter int NUM_IRQ = 128
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic        req_write,
   input  logic [15:0] req_addr,
   input  logic [31:0] req_wdata,
   output logic        rsp_valid,
   output logic [31:0] rsp_rdata,
   output logic        rsp_err
);
   localparam int BIT_WORDS  = NUM_IRQ / 32;
   localparam int PRIO_WORDS = NUM_IRQ / 4;
   localparam int CFG_WORDS  = NUM_IRQ / 16;
   localparam int BIT_FIRST  = PRIV_IRQ / 32;
   localparam int PRIO_FIRST = PRIV_IRQ / 4;
   localparam int CFG_FIRST  = PRIV_IRQ / 16;
   localparam logic [31:0] TYPE_VALUE =
      32'(BIT_WORDS - 1) | (32'(ID_BITS - 1) << 19);

   generate
      if (NUM_IRQ % 32 != 0 || NUM_IRQ < 64 || NUM_IRQ > 1024) begin : g_bad_num
         $error("irq_dist_regfile: NUM_IRQ must be a multiple of 32 in 64..1024");
      end
   endgenerate

   region_e     region;
   logic        wr;
   logic        g1_en_q;
   logic [31:0] ena_word, pnd_word, prio_word, cfg_word;
   logic [31:0] rd_mux;

   assign wr = req_valid && req_write;

   dist_decode u_decode (
      .addr   (req_addr),
      .region (region)
   );

   dist_bitarray #(.NUM_WORDS(BIT_WORDS), .FIRST_WORD(BIT_FIRST), .IDX_W(5)) u_enable (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (wr && region == RG_ENA_SET),
      .clr_en  (wr && region == RG_ENA_CLR),
      .idx     (req_addr[6:2]),
      .wdata   (req_wdata),
      .rd_word (ena_word)
   );

   dist_bitarray #(.NUM_WORDS(BIT_WORDS), .FIRST_WORD(BIT_FIRST), .IDX_W(5)) u_pending (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (wr && region == RG_PND_SET),
      .clr_en  (wr && region == RG_PND_CLR),
      .idx     (req_addr[6:2]),
      .wdata   (req_wdata),
      .rd_word (pnd_word)
   );

   dist_wordarray #(.NUM_WORDS(PRIO_WORDS), .FIRST_WORD(PRIO_FIRST), .IDX_W(8)) u_prio (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr && region == RG_PRIO),
      .idx     (req_addr[9:2]),
      .wdata   (req_wdata),
      .rd_word (prio_word)
   );

   dist_wordarray #(.NUM_WORDS(CFG_WORDS), .FIRST_WORD(CFG_FIRST), .IDX_W(6)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr && region == RG_CFG),
      .idx     (req_addr[7:2]),
      .wdata   (req_wdata),
      .rd_word (cfg_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         g1_en_q <= 1'b0;
      else if (wr && region == RG_CTRL)
         g1_en_q <= req_wdata[1];
   end

   always_comb begin
      unique case (region)
         RG_CTRL:                rd_mux = 32'h0000_0050 | {30'd0, g1_en_q, 1'b0};
         RG_TYPE:                rd_mux = TYPE_VALUE;
         RG_RAO:                 rd_mux = '1;
         RG_ENA_SET, RG_ENA_CLR: rd_mux = ena_word;
         RG_PND_SET, RG_PND_CLR: rd_mux = pnd_word;
         RG_PRIO:                rd_mux = prio_word;
         RG_CFG:                 rd_mux = cfg_word;
         RG_ID2:                 rd_mux = ID2_VALUE;
         default:                rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
         rsp_err   <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         rsp_rdata <= (req_valid && !req_write) ? rd_mux : '0;
         rsp_err   <= req_valid && region == RG_NONE;
      end
   end
endmodule

// File: rtl/dist_chk.sv
module dist_chk #(
   parameter int NUM_IRQ = 128
) (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic        req_write,
   input logic [15:0] req_addr,
   input logic        rsp_valid,
   input logic [31:0] rsp_rdata,
   input logic        rsp_err
);
   localparam logic [31:0] TYPE_EXP = 32'(NUM_IRQ / 32 - 1) | (32'd9 << 19);

   logic rd;
   assign rd = req_valid && !req_write;

   // R14
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R14
   no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   // R2
   ctrl_forced_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && req_addr == 16'h0000) |=>
         (rsp_rdata[6] && rsp_rdata[4] && !rsp_rdata[0] && rsp_rdata[31:7] == '0));

   // R3
   type_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && req_addr == 16'h0004) |=> rsp_rdata == TYPE_EXP);

   // R7
   group_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && req_addr >= 16'h0080 && req_addr < 16'h0100 && req_addr[1:0] == 2'b00)
         |=> rsp_rdata == 32'hFFFF_FFFF);

   // R11
   id2_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && req_addr == 16'hFFE8) |=> rsp_rdata == 32'h0000_003B);

   // R6
   private_enable_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && (req_addr == 16'h0100 || req_addr == 16'h0200)) |=> rsp_rdata == '0);

   // R12
   err_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_valid && rsp_rdata == '0));
endmodule

bind irq_dist_regfile dist_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_addr  (req_addr),
   .rsp_valid (rsp_valid),
   .rsp_rdata (rsp_rdata),
   .rsp_err   (rsp_err)
);

// File: tb/sim_irq_dist_regfile.sv
module sim_irq_dist_regfile;
   localparam int NUM_IRQ = 128;
   localparam int NW      = NUM_IRQ / 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [15:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic        rsp_err;

   int n_tests = 0;
   int n_fail  = 0;

   logic [31:0] m_en  [NW];
   logic [31:0] m_pd  [NW];
   logic [31:0] m_cfg [2*NW];
   logic [31:0] m_pr  [8*NW];
   logic        m_g1;

   always #5 clk = ~clk;

   irq_dist_regfile #(.NUM_IRQ(NUM_IRQ)) u0 (
      .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_write (req_write),
      .req_addr (req_addr), .req_wdata (req_wdata), .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata), .rsp_err (rsp_err)
   );

   function automatic bit decoded(input logic [15:0] a);
      if (a[1:0] != 0) return 0;
      if (a == 16'h0 || a == 16'h4 || a == 16'h10 || a == 16'h40 ||
          a == 16'h48 || a == 16'h50 || a == 16'h58) return 1;
      if (a >= 16'h080 && a < 16'h0D00) return 1;
      if (a >= 16'h0D00 && a < 16'h0D80) return 1;
      if (a >= 16'h0E00 && a < 16'h0F00) return 1;
      if (a == 16'h0F00) return 1;
      if (a >= 16'h0F10 && a < 16'h0F30) return 1;
      if (a >= 16'hFFD0) return 1;
      return 0;
   endfunction

   function automatic string tag_of(input logic [15:0] a);
      int k;
      if (!decoded(a)) return "R12";
      if (a == 16'h0) return "R2";
      if (a == 16'h4) return "R3";
      if (a >= 16'h080 && a < 16'h100) return "R7";
      if (a >= 16'h100 && a < 16'h300) begin
         k = int'(a[6:2]);
         if (k == 0) return "R6";
         if (k >= NW) return "R13";
         return (a < 16'h200) ? "R4" : "R5";
      end
      if (a >= 16'h400 && a < 16'h800) begin
         k = int'(a[9:2]);
         if (k < 8) return "R6";
         if (k >= 8*NW) return "R13";
         return "R8";
      end
      if (a >= 16'hC00 && a < 16'hD00) begin
         k = int'(a[7:2]);
         if (k < 2) return "R6";
         if (k >= 2*NW) return "R13";
         return "R9";
      end
      if (a >= 16'hFFD0) return "R11";
      return "R10";
   endfunction

   function automatic logic [31:0] exp_read(input logic [15:0] a);
      int k;
      if (!decoded(a)) return 32'h0;
      if (a == 16'h0) return 32'h50 | {30'd0, m_g1, 1'b0};
      if (a == 16'h4) return 32'(NW - 1) | (32'd9 << 19);
      if (a >= 16'h080 && a < 16'h100) return 32'hFFFF_FFFF;
      if (a >= 16'h100 && a < 16'h300) begin
         k = int'(a[6:2]);
         if (k == 0 || k >= NW) return 32'h0;
         return (a < 16'h200) ? m_en[k] : m_pd[k];
      end
      if (a >= 16'h400 && a < 16'h800) begin
         k = int'(a[9:2]);
         return (k < 8 || k >= 8*NW) ? 32'h0 : m_pr[k];
      end
      if (a >= 16'hC00 && a < 16'hD00) begin
         k = int'(a[7:2]);
         return (k < 2 || k >= 2*NW) ? 32'h0 : m_cfg[k];
      end
      if (a == 16'hFFE8) return 32'h3B;
      return 32'h0;
   endfunction

   task automatic apply_write(input logic [15:0] a, input logic [31:0] d);
      int k;
      if (!decoded(a)) return;
      if (a == 16'h0) m_g1 = d[1];
      else if (a >= 16'h100 && a < 16'h300) begin
         k = int'(a[6:2]);
         if (k != 0 && k < NW) begin
            if (a < 16'h180)      m_en[k] = m_en[k] | d;
            else if (a < 16'h200) m_en[k] = m_en[k] & ~d;
            else if (a < 16'h280) m_pd[k] = m_pd[k] | d;
            else                  m_pd[k] = m_pd[k] & ~d;
         end
      end else if (a >= 16'h400 && a < 16'h800) begin
         k = int'(a[9:2]);
         if (k >= 8 && k < 8*NW) m_pr[k] = d;
      end else if (a >= 16'hC00 && a < 16'hD00) begin
         k = int'(a[7:2]);
         if (k >= 2 && k < 2*NW) m_cfg[k] = d;
      end
   endtask

   task automatic check(input string tag, input string what,
                        input logic [31:0] got, input logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
      end
   endtask

   task automatic xact(input bit wr, input logic [15:0] a, input logic [31:0] d);
      logic [31:0] e;
      string t;
      t = tag_of(a);
      e = wr ? 32'h0 : exp_read(a);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      // R14: response one cycle after the request
      check("R14", "rsp_valid", {31'd0, rsp_valid}, 32'd1);
      check(t, $sformatf("data @%h", a), rsp_rdata, e);
      check(decoded(a) ? t : "R12", $sformatf("err @%h", a), {31'd0, rsp_err},
            {31'd0, !decoded(a)});
      if (wr) apply_write(a, d);
   endtask

   function automatic logic [15:0] pick_addr();
      case ($urandom % 14)
         0:  return 16'h0000;
         1:  return 16'h0004;
         2:  return 16'h0080 + 16'(($urandom % 32) * 4);
         3:  return 16'h0100 + 16'(($urandom % 32) * 4);
         4:  return 16'h0180 + 16'(($urandom % 8) * 4);
         5:  return 16'h0200 + 16'(($urandom % 8) * 4);
         6:  return 16'h0280 + 16'(($urandom % 8) * 4);
         7:  return 16'h0400 + 16'(($urandom % 40) * 4);
         8:  return 16'h0C00 + 16'(($urandom % 12) * 4);
         9:  return 16'h0300 + 16'(($urandom % 64) * 4);
         10: return 16'h0800 + 16'(($urandom % 256) * 4);
         11: return 16'hFFD0 + 16'(($urandom % 12) * 4);
         12: return 16'(($urandom % 16'h1000) & 16'hFFFC);
         default: return 16'($urandom);
      endcase
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL R14 watchdog: got hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < NW; i++) begin m_en[i] = '0; m_pd[i] = '0; end
      for (int i = 0; i < 2*NW; i++) m_cfg[i] = '0;
      for (int i = 0; i < 8*NW; i++) m_pr[i] = '0;
      m_g1 = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R14", "idle rsp_valid", {31'd0, rsp_valid}, 32'd0);

      // R1 reset state
      xact(0, 16'h0000, 0);
      xact(0, 16'h0104, 0);
      xact(0, 16'h0204, 0);
      xact(0, 16'h0420, 0);
      xact(0, 16'h0C08, 0);

      // R2 control bits
      xact(1, 16'h0000, 32'hFFFF_FFFF);
      xact(0, 16'h0000, 0);
      xact(1, 16'h0000, 32'h0000_0001);
      xact(0, 16'h0000, 0);
      // R3 type register write ignored
      xact(1, 16'h0004, 32'hFFFF_FFFF);
      xact(0, 16'h0004, 0);
      // R4 / R5 set and clear
      xact(1, 16'h0104, 32'hA5A5_0F0F);
      xact(1, 16'h0184, 32'h0000_0F00);
      xact(0, 16'h0104, 0);
      xact(0, 16'h0184, 0);
      xact(1, 16'h0208, 32'h8000_0001);
      xact(1, 16'h0288, 32'h0000_0000);
      xact(0, 16'h0288, 0);
      // R6 private slices
      xact(1, 16'h0100, 32'hFFFF_FFFF);
      xact(1, 16'h0200, 32'hFFFF_FFFF);
      xact(1, 16'h041C, 32'h1234_5678);
      xact(1, 16'h0C04, 32'hFFFF_FFFF);
      xact(0, 16'h0100, 0);
      xact(0, 16'h041C, 0);
      xact(0, 16'h0C04, 0);
      // R13 beyond NUM_IRQ
      xact(1, 16'h0100 + 16'(NW*4), 32'hFFFF_FFFF);
      xact(0, 16'h0100 + 16'(NW*4), 0);
      xact(1, 16'h0400 + 16'(NW*32), 32'hFFFF_FFFF);
      xact(0, 16'h0400 + 16'(NW*32), 0);
      xact(1, 16'h0C00 + 16'(NW*8), 32'hFFFF_FFFF);
      xact(0, 16'h0C00 + 16'(NW*8), 0);
      // R8 / R9 storage
      xact(1, 16'h0424, 32'hDEAD_BEEF);
      xact(0, 16'h0424, 0);
      xact(1, 16'h0C0C, 32'h5555_AAAA);
      xact(0, 16'h0C0C, 0);
      // R7 / R10 / R11
      xact(1, 16'h0080, 32'h0);
      xact(0, 16'h0080, 0);
      xact(1, 16'h0F00, 32'hFFFF_FFFF);
      xact(0, 16'h0F00, 0);
      xact(1, 16'h0840, 32'hFFFF_FFFF);
      xact(0, 16'h0840, 0);
      xact(0, 16'hFFE8, 0);
      xact(0, 16'hFFEC, 0);
      // R12 undecoded and misaligned
      xact(0, 16'h0008, 0);
      xact(1, 16'h6100, 32'hFFFF_FFFF);
      xact(0, 16'h0105, 0);
      xact(1, 16'h0D80, 32'hFFFF_FFFF);

      // random traffic
      for (int i = 0; i < 3000; i++) begin
         logic [15:0] a;
         a = pick_addr();
         xact(1'($urandom % 2), a, $urandom);
      end

      // final sweep of all stored state (R4 R5 R8 R9)
      for (int i = 0; i < 32; i++) xact(0, 16'h0100 + 16'(i*4), 0);
      for (int i = 0; i < 32; i++) xact(0, 16'h0200 + 16'(i*4), 0);
      for (int i = 0; i < 8*NW + 4; i++) xact(0, 16'h0400 + 16'(i*4), 0);
      for (int i = 0; i < 2*NW + 4; i++) xact(0, 16'h0C00 + 16'(i*4), 0);
      xact(0, 16'h0000, 0);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule